// File: doc/BRIEF.md
# CAN identifier acceptance filter

This block decides, for every identifier a CAN receiver hands it, whether the message is wanted. Software fills a table of 512 words of 32 bits with sorted identifier entries. Each word holds either two 11-bit (standard) entries or one 29-bit (extended) entry. Software also sets the word range of the standard section and of the extended section. When a receiver presents an identifier with its format flag and controller number, the filter runs a binary search over the matching section. It then returns a one-cycle verdict with the index of the matched entry and a flag for entries that software has switched off.

A two-bit mode register controls both the verdict and who may write. With the off bit set and the bypass bit clear, every message is rejected. With the bypass bit set, every message is accepted. In both of these modes the search engine stays idle and the CPU may freely rewrite the table and the section registers. With both bits clear, the hardware search runs. The section registers are then frozen, and the CPU may change only the per-entry disable bits of the standard section.

Top module: `can_id_filter`

## Requirements
- R1: After reset the mode register reads 1 (off bit set, bypass clear), rx_ready is 1, and res_valid and cpu_err are 0.
- R2: Every CPU access whose byte enables are not all ones is ignored: nothing is written, cpu_rdata keeps its value, and cpu_err is 1 for the one cycle after the access edge.
- R3: Mode field bits are [1] bypass and [0] off. In Off mode (value 1), a request taken at a clock edge yields res_valid=1 with res_accept=0 after that same edge.
- R4: In Bypass mode (mode bit 1 set), a request taken at a clock edge yields res_valid=1 with res_accept=1 after that same edge.
- R5: In Off and Bypass modes, CPU writes reach both the table (cpu_cfg=0) and the configuration registers (cpu_cfg=1). In the configuration space, address 0 is the mode, 1 and 2 are the first and last word of the standard section, and 3 and 4 are the first and last word of the extended section. A read returns the value on cpu_rdata after the access edge.
- R6: In Running mode (value 0), a standard request is searched in the standard section. There, entry 2w is word w bits [15:0] and entry 2w+1 is bits [31:16]. Each entry holds controller in [15:13], disable in [12], zero in [11] and identifier in [10:0]. Entries are sorted ascending by {controller, identifier}. An enabled exact match gives res_accept=1 and res_idx equal to the entry number.
- R7: In Running mode, an extended request is searched in the extended section. There, a word holds controller in [31:29] and identifier in [28:0], sorted ascending as a 32-bit value. A match gives res_accept=1 and res_idx equal to the word address.
- R8: A match on a standard entry whose disable bit is set gives res_accept=0, res_dis=1 and the entry's index. A miss gives res_accept=0 and res_dis=0.
- R9: In Running mode, rx_ready drops in the cycle after a request is taken. The verdict arrives between 1 and 11 clock edges after the taking edge.
- R10: In Running mode, a table write to a word inside the standard section changes only bits 12 and 28 of that word. A table write to any other word is ignored.
- R11: In Running mode, writes to configuration addresses 1 to 4 are ignored and raise cpu_err for one cycle. The mode register stays writable in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_en | input | 1 | CPU access strobe, one cycle per access |
| cpu_we | input | 1 | 1 for write, 0 for read |
| cpu_cfg | input | 1 | 1 selects the configuration space, 0 the table |
| cpu_addr | input | 9 | Word address |
| cpu_be | input | 4 | Byte enables; only 4'hF is a legal access |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, held until the next read |
| cpu_err | output | 1 | One-cycle flag for a rejected access |
| rx_valid | input | 1 | Identifier request present |
| rx_ready | output | 1 | Filter can take a request |
| rx_ext | input | 1 | 1 for a 29-bit identifier, 0 for an 11-bit one |
| rx_ctrl | input | 3 | Number of the receiving controller |
| rx_id | input | 29 | Identifier; standard requests use bits [10:0] |
| res_valid | output | 1 | One-cycle verdict strobe |
| res_accept | output | 1 | 1 when the message is accepted |
| res_idx | output | 10 | Index of the matched entry |
| res_dis | output | 1 | Matched entry has its disable bit set |

## Verification
In Off and Bypass modes the verdict is registered at the same edge that takes the request, so the bench expects res_valid at the next falling edge with no extra edges. In Running mode the bench counts falling edges until res_valid. It requires a count between 1 and 11, and it checks rx_ready low at the first falling edge after the request for a search that needs more than one probe. CPU read data and cpu_err are registered at the access edge, so the bench samples both at the falling edge that follows that edge.

// File: rtl/canaf_pkg.sv
package canaf_pkg;

    localparam logic [31:0] DIS_MASK = 32'h1000_1000;

    typedef enum logic {
        SRCH_IDLE = 1'b0,
        SRCH_BUSY = 1'b1
    } srch_e;

    // comparison key of one 16-bit standard entry: {controller, spare, id}
    function automatic logic [31:0] std_entry_key(input logic [15:0] e);
        return {17'd0, e[15:13], e[11], e[10:0]};
    endfunction

    function automatic logic [31:0] std_req_key(input logic [2:0] c, input logic [10:0] id);
        return {17'd0, c, 1'b0, id};
    endfunction

endpackage

// File: rtl/canaf_table.sv
module canaf_table #(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [31:0]   wdata,
    input  logic [31:0]   wmask,
    input  logic [AW-1:0] raddr_a,
    output logic [31:0]   rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [31:0]   rdata_b
);
    localparam int DEPTH = 1 << AW;

    logic [31:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= (mem[waddr] & ~wmask) | (wdata & wmask);
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/canaf_cpu.sv
module canaf_cpu
    import canaf_pkg::*;
#(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_en,
    input  logic          cpu_we,
    input  logic          cpu_cfg,
    input  logic [AW-1:0] cpu_addr,
    input  logic [3:0]    cpu_be,
    input  logic [31:0]   cpu_wdata,
    output logic [31:0]   cpu_rdata,
    output logic          cpu_err,
    input  logic [31:0]   tbl_rdata,
    output logic          tbl_we,
    output logic [31:0]   tbl_wmask,
    output logic [1:0]    mode,
    output logic [AW-1:0] std_first,
    output logic [AW-1:0] std_last,
    output logic [AW-1:0] ext_first,
    output logic [AW-1:0] ext_last
);
    typedef struct packed {
        logic [1:0]    mode;
        logic [AW-1:0] ss, se, xs, xe;
        logic [31:0]   rdata;
        logic          err;
    } cpu_st_t;

    cpu_st_t st_q, st_d;
    logic        running, in_std;
    logic [31:0] cfg_rd;

    always_comb begin
        st_d      = st_q;
        st_d.err  = 1'b0;
        tbl_we    = 1'b0;
        tbl_wmask = '1;
        running   = (st_q.mode == 2'b00);
        in_std    = (cpu_addr >= st_q.ss) && (cpu_addr <= st_q.se);
        case (cpu_addr)
            AW'(0):  cfg_rd = {30'd0, st_q.mode};
            AW'(1):  cfg_rd = 32'(st_q.ss);
            AW'(2):  cfg_rd = 32'(st_q.se);
            AW'(3):  cfg_rd = 32'(st_q.xs);
            AW'(4):  cfg_rd = 32'(st_q.xe);
            default: cfg_rd = 32'd0;
        endcase
        if (cpu_en) begin
            if (cpu_be != 4'hF) begin
                st_d.err = 1'b1;
            end else if (cpu_we && cpu_cfg) begin
                if (cpu_addr == AW'(0)) begin
                    st_d.mode = cpu_wdata[1:0];
                end else if (cpu_addr <= AW'(4)) begin
                    if (running) st_d.err = 1'b1;
                    else begin
                        case (cpu_addr)
                            AW'(1):  st_d.ss = cpu_wdata[AW-1:0];
                            AW'(2):  st_d.se = cpu_wdata[AW-1:0];
                            AW'(3):  st_d.xs = cpu_wdata[AW-1:0];
                            default: st_d.xe = cpu_wdata[AW-1:0];
                        endcase
                    end
                end
            end else if (cpu_we) begin
                if (!running) tbl_we = 1'b1;
                else if (in_std) begin
                    tbl_we    = 1'b1;
                    tbl_wmask = DIS_MASK;
                end
            end else begin
                st_d.rdata = cpu_cfg ? cfg_rd : tbl_rdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mode <= 2'b01;
        end else begin
            st_q <= st_d;
        end
    end

    assign cpu_rdata = st_q.rdata;
    assign cpu_err   = st_q.err;
    assign mode      = st_q.mode;
    assign std_first = st_q.ss;
    assign std_last  = st_q.se;
    assign ext_first = st_q.xs;
    assign ext_last  = st_q.xe;

    assert_partial_err_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_en && cpu_be != 4'hF) |=> (cpu_err && $stable(cpu_rdata) && $stable(mode)));

    assert_cfg_locked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_en && cpu_we && cpu_cfg && mode == 2'b00 && cpu_addr != AW'(0) && cpu_addr <= AW'(4))
        |=> (cpu_err && $stable(std_first) && $stable(std_last) && $stable(ext_first) && $stable(ext_last)));
endmodule

// File: rtl/canaf_search.sv
module canaf_search
    import canaf_pkg::*;
#(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode,
    input  logic [AW-1:0] std_first,
    input  logic [AW-1:0] std_last,
    input  logic [AW-1:0] ext_first,
    input  logic [AW-1:0] ext_last,
    input  logic          rx_valid,
    output logic          rx_ready,
    input  logic          rx_ext,
    input  logic [2:0]    rx_ctrl,
    input  logic [28:0]   rx_id,
    output logic [AW-1:0] probe_addr,
    input  logic [31:0]   probe_data,
    output logic          res_valid,
    output logic          res_accept,
    output logic [AW:0]   res_idx,
    output logic          res_dis
);
    localparam int IW = AW + 1;
    localparam int RW = AW + 2;

    typedef struct packed {
        srch_e         st;
        logic          ext;
        logic [31:0]   key;
        logic [RW-1:0] lo, hi;
        logic          rv, racc, rdis;
        logic [IW-1:0] ridx;
    } srch_st_t;

    srch_st_t q, d;
    logic          running;
    logic [RW-1:0] sum, mid, nlo, nhi, lo0, hi0;
    logic [15:0]   half;
    logic [31:0]   ekey;

    always_comb begin
        d       = q;
        d.rv    = 1'b0;
        running = (mode == 2'b00);
        sum     = q.lo + q.hi;
        mid     = sum >> 1;
        half    = mid[0] ? probe_data[31:16] : probe_data[15:0];
        ekey    = q.ext ? probe_data : std_entry_key(half);
        probe_addr = q.ext ? mid[AW-1:0] : mid[AW:1];
        nlo     = q.lo;
        nhi     = q.hi;
        lo0     = rx_ext ? RW'(ext_first) : RW'({std_first, 1'b0});
        hi0     = rx_ext ? RW'(ext_last) + RW'(1) : RW'({std_last, 1'b0}) + RW'(2);
        if (q.st == SRCH_IDLE) begin
            if (rx_valid) begin
                d.rdis = 1'b0;
                d.ridx = '0;
                if (!running) begin
                    d.rv   = 1'b1;
                    d.racc = mode[1];
                end else if (lo0 < hi0) begin
                    d.st  = SRCH_BUSY;
                    d.ext = rx_ext;
                    d.key = rx_ext ? {rx_ctrl, rx_id} : std_req_key(rx_ctrl, rx_id[10:0]);
                    d.lo  = lo0;
                    d.hi  = hi0;
                end else begin
                    d.rv   = 1'b1;
                    d.racc = 1'b0;
                end
            end
        end else if (!running) begin
            d.st   = SRCH_IDLE;
            d.rv   = 1'b1;
            d.racc = mode[1];
        end else if (ekey == q.key) begin
            d.st   = SRCH_IDLE;
            d.rv   = 1'b1;
            d.rdis = !q.ext && half[12];
            d.racc = !d.rdis;
            d.ridx = mid[IW-1:0];
        end else begin
            if (q.key < ekey) nhi = mid;
            else              nlo = mid + RW'(1);
            d.lo = nlo;
            d.hi = nhi;
            if (nlo >= nhi) begin
                d.st   = SRCH_IDLE;
                d.rv   = 1'b1;
                d.racc = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rx_ready   = (q.st == SRCH_IDLE);
    assign res_valid  = q.rv;
    assign res_accept = q.racc;
    assign res_idx    = q.ridx;
    assign res_dis    = q.rdis;

    assert_off_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready && mode == 2'b01) |=> (res_valid && !res_accept));

    assert_bypass_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready && mode[1]) |=> (res_valid && res_accept));

    assert_dis_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_dis) |-> !res_accept);

    assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready && mode == 2'b00) |=> (!rx_ready || res_valid));
endmodule

// File: rtl/can_id_filter.sv
module can_id_filter
    import canaf_pkg::*;
#(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_en,
    input  logic          cpu_we,
    input  logic          cpu_cfg,
    input  logic [AW-1:0] cpu_addr,
    input  logic [3:0]    cpu_be,
    input  logic [31:0]   cpu_wdata,
    output logic [31:0]   cpu_rdata,
    output logic          cpu_err,
    input  logic          rx_valid,
    output logic          rx_ready,
    input  logic          rx_ext,
    input  logic [2:0]    rx_ctrl,
    input  logic [28:0]   rx_id,
    output logic          res_valid,
    output logic          res_accept,
    output logic [AW:0]   res_idx,
    output logic          res_dis
);
    logic [1:0]    mode;
    logic [AW-1:0] std_first, std_last, ext_first, ext_last, probe_addr;
    logic [31:0]   tbl_rdata, probe_data, tbl_wmask;
    logic          tbl_we;

    canaf_cpu #(.AW(AW)) u_cpu (
        .clk(clk), .rst_n(rst_n),
        .cpu_en(cpu_en), .cpu_we(cpu_we), .cpu_cfg(cpu_cfg), .cpu_addr(cpu_addr),
        .cpu_be(cpu_be), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_err(cpu_err),
        .tbl_rdata(tbl_rdata), .tbl_we(tbl_we), .tbl_wmask(tbl_wmask), .mode(mode),
        .std_first(std_first), .std_last(std_last), .ext_first(ext_first), .ext_last(ext_last)
    );

    canaf_table #(.AW(AW)) u_table (
        .clk(clk), .we(tbl_we), .waddr(cpu_addr), .wdata(cpu_wdata), .wmask(tbl_wmask),
        .raddr_a(cpu_addr), .rdata_a(tbl_rdata), .raddr_b(probe_addr), .rdata_b(probe_data)
    );

    canaf_search #(.AW(AW)) u_search (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .std_first(std_first), .std_last(std_last), .ext_first(ext_first), .ext_last(ext_last),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_ext(rx_ext), .rx_ctrl(rx_ctrl), .rx_id(rx_id),
        .probe_addr(probe_addr), .probe_data(probe_data),
        .res_valid(res_valid), .res_accept(res_accept), .res_idx(res_idx), .res_dis(res_dis)
    );

    assert_run_write_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_we && mode == 2'b00) |-> ((tbl_wmask & ~DIS_MASK) == 32'd0));
endmodule

// File: tb/can_id_filter_tb.sv
module can_id_filter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_en = 0, cpu_we = 0, cpu_cfg = 0;
    logic [8:0]  cpu_addr = '0;
    logic [3:0]  cpu_be = 4'hF;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_err;
    logic        rx_valid = 0, rx_ext = 0;
    logic        rx_ready;
    logic [2:0]  rx_ctrl = '0;
    logic [28:0] rx_id = '0;
    logic        res_valid, res_accept, res_dis;
    logic [9:0]  res_idx;

    int n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    can_id_filter u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_en(cpu_en), .cpu_we(cpu_we), .cpu_cfg(cpu_cfg),
        .cpu_addr(cpu_addr), .cpu_be(cpu_be), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_err(cpu_err), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_ext(rx_ext),
        .rx_ctrl(rx_ctrl), .rx_id(rx_id), .res_valid(res_valid), .res_accept(res_accept),
        .res_idx(res_idx), .res_dis(res_dis)
    );

    // {ext, ctrl, id, accept, idx, dis}
    localparam logic [44:0] VECS [12] = '{
        {1'b0, 3'd1, 29'h010,       1'b1, 10'd0,  1'b0},
        {1'b0, 3'd1, 29'h7FF,       1'b1, 10'd3,  1'b0},
        {1'b0, 3'd3, 29'h001,       1'b1, 10'd7,  1'b0},
        {1'b0, 3'd2, 29'h050,       1'b0, 10'd5,  1'b1},
        {1'b0, 3'd1, 29'h011,       1'b0, 10'd0,  1'b0},
        {1'b0, 3'd2, 29'h300,       1'b1, 10'd6,  1'b0},
        {1'b1, 3'd1, 29'h1000,      1'b1, 10'd16, 1'b0},
        {1'b1, 3'd1, 29'h1ABCDEF0,  1'b1, 10'd17, 1'b0},
        {1'b1, 3'd2, 29'h1,         1'b1, 10'd18, 1'b0},
        {1'b1, 3'd1, 29'h1001,      1'b0, 10'd0,  1'b0},
        {1'b0, 3'd0, 29'h010,       1'b0, 10'd0,  1'b0},
        {1'b1, 3'd3, 29'h5,         1'b0, 10'd0,  1'b0}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic cpu_acc(input bit we, input bit cfg, input logic [8:0] a,
                           input logic [31:0] wd, input logic [3:0] be);
        @(negedge clk);
        cpu_en = 1; cpu_we = we; cpu_cfg = cfg; cpu_addr = a; cpu_wdata = wd; cpu_be = be;
        @(negedge clk);
        cpu_en = 0; cpu_we = 0; cpu_be = 4'hF;
    endtask

    task automatic lookup(input bit ext, input logic [2:0] c, input logic [28:0] id,
                          output bit acc, output logic [9:0] idx, output bit dis,
                          output int edges, output bit rdy_after);
        @(negedge clk);
        while (!rx_ready) @(negedge clk);
        rx_valid = 1; rx_ext = ext; rx_ctrl = c; rx_id = id;
        @(negedge clk);
        rx_valid = 0;
        rdy_after = rx_ready;
        edges = 0;
        while (!res_valid && edges < 20) begin
            @(negedge clk);
            edges++;
        end
        acc = res_accept; idx = res_idx; dis = res_dis;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        bit acc, dis, rdy;
        logic [9:0] idx;
        int edges;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk(rx_ready === 1'b1, "R1", "rx_ready", 32'(rx_ready), 1);
        chk(res_valid === 1'b0 && cpu_err === 1'b0, "R1", "res_valid|cpu_err",
            {30'd0, res_valid, cpu_err}, 0);
        rst_n = 1;
        cpu_acc(0, 1, 9'd0, 0, 4'hF);
        chk(cpu_rdata === 32'd1, "R1", "mode after reset", cpu_rdata, 1);

        // R5: load table and sections in Off mode
        cpu_acc(1, 0, 9'd0,  32'h2020_2010, 4'hF);
        cpu_acc(1, 0, 9'd1,  32'h27FF_2100, 4'hF);
        cpu_acc(1, 0, 9'd2,  32'h5050_4005, 4'hF);
        cpu_acc(1, 0, 9'd3,  32'h6001_4300, 4'hF);
        cpu_acc(1, 0, 9'd16, 32'h2000_1000, 4'hF);
        cpu_acc(1, 0, 9'd17, 32'h3ABC_DEF0, 4'hF);
        cpu_acc(1, 0, 9'd18, 32'h4000_0001, 4'hF);
        cpu_acc(1, 1, 9'd1, 32'd0,  4'hF);
        cpu_acc(1, 1, 9'd2, 32'd3,  4'hF);
        cpu_acc(1, 1, 9'd3, 32'd16, 4'hF);
        cpu_acc(1, 1, 9'd4, 32'd18, 4'hF);
        cpu_acc(0, 0, 9'd2, 0, 4'hF);
        chk(cpu_rdata === 32'h5050_4005, "R5", "table readback", cpu_rdata, 32'h5050_4005);
        cpu_acc(0, 1, 9'd3, 0, 4'hF);
        chk(cpu_rdata === 32'd16, "R5", "ext_first readback", cpu_rdata, 16);

        // R3: Off mode rejects at the taking edge
        lookup(0, 3'd1, 29'h010, acc, idx, dis, edges, rdy);
        chk(edges == 0 && res_valid, "R3", "off latency", edges, 0);
        chk(acc == 0, "R3", "off verdict", 32'(acc), 0);

        // R4: Bypass accepts at the taking edge
        cpu_acc(1, 1, 9'd0, 32'd2, 4'hF);
        lookup(0, 3'd5, 29'h123, acc, idx, dis, edges, rdy);
        chk(edges == 0 && res_valid, "R4", "bypass latency", edges, 0);
        chk(acc == 1, "R4", "bypass verdict", 32'(acc), 1);

        // R2: partial access ignored and flagged
        cpu_acc(1, 0, 9'd30, 32'h1234_5678, 4'hF);
        cpu_acc(1, 0, 9'd30, 32'hFFFF_FFFF, 4'h3);
        chk(cpu_err === 1'b1, "R2", "partial write err", 32'(cpu_err), 1);
        cpu_acc(0, 0, 9'd30, 0, 4'hF);
        chk(cpu_rdata === 32'h1234_5678, "R2", "partial write ignored", cpu_rdata, 32'h1234_5678);
        cpu_acc(0, 0, 9'd0, 0, 4'h1);
        chk(cpu_err === 1'b1 && cpu_rdata === 32'h1234_5678, "R2", "partial read",
            cpu_rdata, 32'h1234_5678);

        // Running mode: vector table (R6 R7 R8 R9)
        cpu_acc(1, 1, 9'd0, 32'd0, 4'hF);
        for (int i = 0; i < 12; i++) begin
            logic [44:0] v;
            v = VECS[i];
            lookup(v[44], v[43:41], v[40:12], acc, idx, dis, edges, rdy);
            chk(edges >= 1 && edges <= 11, "R9", $sformatf("vector %0d latency", i), edges, 11);
            chk(acc == v[11], v[44] ? "R7" : "R6", $sformatf("vector %0d accept", i),
                32'(acc), 32'(v[11]));
            chk(dis == v[0], "R8", $sformatf("vector %0d dis", i), 32'(dis), 32'(v[0]));
            if (v[11] || v[0])
                chk(idx == v[10:1], v[44] ? "R7" : "R6", $sformatf("vector %0d idx", i),
                    32'(idx), 32'(v[10:1]));
        end

        // R9: ready drops while a multi-probe search runs
        lookup(0, 3'd1, 29'h010, acc, idx, dis, edges, rdy);
        chk(rdy == 0, "R9", "rx_ready during search", 32'(rdy), 0);

        // R11: section registers locked while running, mode writable
        cpu_acc(1, 1, 9'd2, 32'd0, 4'hF);
        chk(cpu_err === 1'b1, "R11", "locked cfg err", 32'(cpu_err), 1);
        cpu_acc(0, 1, 9'd2, 0, 4'hF);
        chk(cpu_rdata === 32'd3, "R11", "std_last unchanged", cpu_rdata, 3);
        lookup(0, 3'd3, 29'h001, acc, idx, dis, edges, rdy);
        chk(acc == 1 && idx == 10'd7, "R11", "last entry still found", 32'(idx), 7);

        // R10: running writes touch only disable bits of the standard section
        cpu_acc(1, 0, 9'd2, 32'd0, 4'hF);
        cpu_acc(0, 0, 9'd2, 0, 4'hF);
        chk(cpu_rdata === 32'h4050_4005, "R10", "disable bit cleared only", cpu_rdata, 32'h4050_4005);
        lookup(0, 3'd2, 29'h050, acc, idx, dis, edges, rdy);
        chk(acc == 1 && dis == 0 && idx == 10'd5, "R10", "re-enabled entry", 32'(idx), 5);
        cpu_acc(1, 0, 9'd16, 32'd0, 4'hF);
        cpu_acc(0, 0, 9'd16, 0, 4'hF);
        chk(cpu_rdata === 32'h2000_1000, "R10", "ext word unchanged", cpu_rdata, 32'h2000_1000);

        // R11: mode switch back to Off while running
        cpu_acc(1, 1, 9'd0, 32'd1, 4'hF);
        cpu_acc(0, 1, 9'd0, 0, 4'hF);
        chk(cpu_rdata === 32'd1, "R11", "mode writable", cpu_rdata, 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule